// File: doc/BRIEF.md
# Set-Associative Page Translation Lookup

This block maps a 32-bit virtual address onto a physical address through a small set-associative translation buffer with 4 KiB pages. A caller strobes a lookup with the virtual address, the current process identifier and the access kind. One cycle later the block returns a hit flag, the physical address, the read, write and execute permissions, the cacheable attribute and the way that supplied the entry. The access kind is passed back with the result but does not affect matching. Comparing it against the permissions, and raising any fault, is left to the caller.

The entries sit in a parameterised array. A separate management block fills it through a simple write port that takes an entry index, a tag word and a data word. For each way, the lookup checks one slot only: slot = way × NUM_WAYS + (VPN & (NUM_ENTRIES/NUM_WAYS − 1)). This layout assumes NUM_ENTRIES/NUM_WAYS ≥ NUM_WAYS. All ways are compared in parallel, and the lowest-numbered way that matches supplies the result.

Top module: `vtlb_lookup`

## Requirements
- R1: A synchronous active-high reset invalidates every entry and clears rs_valid and rs_hit. A lookup made after reset misses until new entries are written.
- R2: When wr_en is high at a clock edge, the entry at wr_index takes wr_tag and wr_data. The new contents apply to lookups strobed from the next cycle onward, and a second write to the same index replaces the first.
- R3: A way matches only if all of these hold: tag bits 31:12 equal the VPN (vaddr bits 31:12), the valid bit (tag bit 10) is set, and either the global bit (tag bit 11) is set or tag bits PID_BITS−1:0 equal lk_pid.
- R4: When more than one way matches, the lowest-numbered way wins, and its number appears on rs_way.
- R5: On a hit, rs_paddr is the PFN (data bits 19:0) in bits 31:12, with vaddr bits 11:0 below it. On a miss, rs_paddr is zero.
- R6: On a hit, rs_rd, rs_wr, rs_ex and rs_cache reflect data bits 22, 21, 20 and 23. On a miss, all four are zero.
- R7: rs_valid is high exactly one cycle after lk_valid is high. While no lookup is strobed, all result fields hold their values.
- R8: rs_acc returns the lk_acc value of the lookup (0 read, 1 write, 2 fetch), and the access kind has no effect on hit, address or permissions.
- R9: An entry written into a slot whose set differs from VPN & mask is never matched, even if its tag would otherwise match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Entry write strobe |
| wr_index | input | IDX_W | Entry slot to write |
| wr_tag | input | 32 | Tag word: VPN, global, valid, process ID |
| wr_data | input | 32 | Data word: PFN, X, W, R, C |
| lk_valid | input | 1 | Lookup strobe |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| lk_pid | input | PID_BITS | Current process identifier |
| rs_valid | output | 1 | Result valid, one cycle after the strobe |
| rs_hit | output | 1 | Translation found |
| rs_paddr | output | 32 | Physical address |
| rs_rd | output | 1 | Read permitted |
| rs_wr | output | 1 | Write permitted |
| rs_ex | output | 1 | Execute permitted |
| rs_cache | output | 1 | Cacheable attribute |
| rs_acc | output | 2 | Access kind returned with the result |
| rs_way | output | WAY_W | Way that supplied the hit |

## Verification
A corrupted stored entry or a wrong set computation shows up on the very next lookup of that page, one cycle after the strobe. It appears as a wrong hit flag, a wrong page frame in rs_paddr bits 31:12, or wrong permission bits. A faulty priority choice shows in rs_way and in the frame delivered when two ways hold the same page. A missing valid or process-ID gate turns an expected miss into a hit. Errors in the output register show as an rs_valid that does not follow the strobe by one cycle, or as results that change while no lookup is made.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

    localparam int PG_SHIFT = 12;
    localparam int VPN_W    = 32 - PG_SHIFT;
    localparam int PFN_W    = 20;

    // tag word bit positions
    localparam int TG_GLOBAL = 11;
    localparam int TG_VALID  = 10;

    // data word bit positions
    localparam int DT_X = 20;
    localparam int DT_W = 21;
    localparam int DT_R = 22;
    localparam int DT_C = 23;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    // compare key kept per entry (process ID stored separately, width is a parameter)
    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic             glob;
        logic             vld;
    } tkey_t;

    // translation payload kept per entry
    typedef struct packed {
        logic             c;
        logic             r;
        logic             w;
        logic             x;
        logic [PFN_W-1:0] pfn;
    } xlat_t;

    function automatic tkey_t key_of(input logic [31:0] tag);
        tkey_t k;
        k.vpn  = tag[31:PG_SHIFT];
        k.glob = tag[TG_GLOBAL];
        k.vld  = tag[TG_VALID];
        return k;
    endfunction

    function automatic xlat_t xlat_of(input logic [31:0] d);
        xlat_t t;
        t.c   = d[DT_C];
        t.r   = d[DT_R];
        t.w   = d[DT_W];
        t.x   = d[DT_X];
        t.pfn = d[PFN_W-1:0];
        return t;
    endfunction

endpackage

// File: rtl/tlbx_store.sv
module tlbx_store
    import tlbx_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_WAYS    = 4,
    parameter int PID_BITS    = 8,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int SETS       = NUM_ENTRIES / NUM_WAYS,
    localparam int SET_W      = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [IDX_W-1:0]                   wr_index,
    input  logic [31:0]                        wr_tag,
    input  logic [31:0]                        wr_data,
    input  logic [SET_W-1:0]                   set_idx,
    output tkey_t [NUM_WAYS-1:0]               rd_key,
    output logic  [NUM_WAYS-1:0][PID_BITS-1:0] rd_pid,
    output xlat_t [NUM_WAYS-1:0]               rd_xl
);

    tkey_t               key_q [NUM_ENTRIES];
    logic [PID_BITS-1:0] pid_q [NUM_ENTRIES];
    xlat_t               xl_q  [NUM_ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                key_q[i] <= '0;
                pid_q[i] <= '0;
                xl_q[i]  <= '0;
            end
        end else if (wr_en) begin
            key_q[wr_index] <= key_of(wr_tag);
            pid_q[wr_index] <= wr_tag[PID_BITS-1:0];
            xl_q[wr_index]  <= xlat_of(wr_data);
        end
    end

    // each way reads slot way*NUM_WAYS + set
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
        logic [IDX_W-1:0] slot;
        assign slot      = IDX_W'(w * NUM_WAYS) + IDX_W'(set_idx);
        assign rd_key[w] = key_q[slot];
        assign rd_pid[w] = pid_q[slot];
        assign rd_xl[w]  = xl_q[slot];
    end

endmodule

// File: rtl/tlbx_way_match.sv
module tlbx_way_match
    import tlbx_pkg::*;
#(
    parameter int PID_BITS = 8
) (
    input  tkey_t               key,
    input  logic [PID_BITS-1:0] ent_pid,
    input  logic [VPN_W-1:0]    vpn,
    input  logic [PID_BITS-1:0] cur_pid,
    output logic                hit
);

    logic vpn_eq;
    logic pid_ok;

    assign vpn_eq = (key.vpn == vpn);
    assign pid_ok = key.glob || (ent_pid == cur_pid);
    assign hit    = key.vld && vpn_eq && pid_ok;

endmodule

// File: rtl/tlbx_hit_pick.sv
module tlbx_hit_pick
    import tlbx_pkg::*;
#(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic  [NUM_WAYS-1:0] hits,
    input  xlat_t [NUM_WAYS-1:0] xl_in,
    output logic                 any,
    output logic  [WAY_W-1:0]    way,
    output xlat_t                xl_out
);

    always_comb begin
        any    = 1'b0;
        way    = '0;
        xl_out = '0;
        // scan downward so the lowest matching way is the last one kept
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (hits[w]) begin
                any    = 1'b1;
                way    = WAY_W'(w);
                xl_out = xl_in[w];
            end
        end
    end

endmodule

// File: rtl/vtlb_lookup.sv
module vtlb_lookup
    import tlbx_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_WAYS    = 4,
    parameter int PID_BITS    = 8,
    localparam int IDX_W      = $clog2(NUM_ENTRIES),
    localparam int WAY_W      = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int SETS       = NUM_ENTRIES / NUM_WAYS,
    localparam int SET_W      = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_index,
    input  logic [31:0]         wr_tag,
    input  logic [31:0]         wr_data,
    input  logic                lk_valid,
    input  logic [31:0]         lk_vaddr,
    input  logic [1:0]          lk_acc,
    input  logic [PID_BITS-1:0] lk_pid,
    output logic                rs_valid,
    output logic                rs_hit,
    output logic [31:0]         rs_paddr,
    output logic                rs_rd,
    output logic                rs_wr,
    output logic                rs_ex,
    output logic                rs_cache,
    output logic [1:0]          rs_acc,
    output logic [WAY_W-1:0]    rs_way
);

    logic [VPN_W-1:0]              vpn;
    logic [SET_W-1:0]              set_idx;
    tkey_t [NUM_WAYS-1:0]          rd_key;
    logic  [NUM_WAYS-1:0][PID_BITS-1:0] rd_pid;
    xlat_t [NUM_WAYS-1:0]          rd_xl;
    logic  [NUM_WAYS-1:0]          hits;
    logic                          any;
    logic  [WAY_W-1:0]             sel_way;
    xlat_t                         sel_xl;
    acc_e                          acc;

    assign vpn     = lk_vaddr[31:PG_SHIFT];
    assign set_idx = SET_W'(vpn & VPN_W'(SETS - 1));
    assign acc     = acc_e'(lk_acc);

    tlbx_store #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .NUM_WAYS    (NUM_WAYS),
        .PID_BITS    (PID_BITS)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_index (wr_index),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data),
        .set_idx  (set_idx),
        .rd_key   (rd_key),
        .rd_pid   (rd_pid),
        .rd_xl    (rd_xl)
    );

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        tlbx_way_match #(
            .PID_BITS (PID_BITS)
        ) u_match (
            .key     (rd_key[w]),
            .ent_pid (rd_pid[w]),
            .vpn     (vpn),
            .cur_pid (lk_pid),
            .hit     (hits[w])
        );
    end

    tlbx_hit_pick #(
        .NUM_WAYS (NUM_WAYS)
    ) u_pick (
        .hits   (hits),
        .xl_in  (rd_xl),
        .any    (any),
        .way    (sel_way),
        .xl_out (sel_xl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            rs_paddr <= '0;
            rs_rd    <= 1'b0;
            rs_wr    <= 1'b0;
            rs_ex    <= 1'b0;
            rs_cache <= 1'b0;
            rs_acc   <= ACC_READ;
            rs_way   <= '0;
        end else begin
            rs_valid <= lk_valid;
            if (lk_valid) begin
                rs_hit   <= any;
                rs_paddr <= any ? {sel_xl.pfn, lk_vaddr[PG_SHIFT-1:0]} : '0;
                rs_rd    <= sel_xl.r;
                rs_wr    <= sel_xl.w;
                rs_ex    <= sel_xl.x;
                rs_cache <= sel_xl.c;
                rs_acc   <= acc;
                rs_way   <= sel_way;
            end
        end
    end

endmodule

// File: rtl/vtlb_lookup_chk.sv
module vtlb_lookup_chk #(
    parameter int WAY_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic [31:0]      lk_vaddr,
    input logic [1:0]       lk_acc,
    input logic             rs_valid,
    input logic             rs_hit,
    input logic [31:0]      rs_paddr,
    input logic             rs_rd,
    input logic             rs_wr,
    input logic             rs_ex,
    input logic             rs_cache,
    input logic [1:0]       rs_acc,
    input logic [WAY_W-1:0] rs_way
);

    // R7: result strobe follows the lookup strobe by exactly one cycle
    p_strobe_follow_r7: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rs_valid);
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rs_valid);

    // R7: results hold while idle
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> ($stable(rs_hit) && $stable(rs_paddr) && $stable(rs_way)));

    // R5: page offset passes straight through on a hit
    p_offset_r5: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (!rs_hit || rs_paddr[11:0] == $past(lk_vaddr[11:0])));

    // R5 / R6: a miss carries no address and no attributes
    p_miss_clean_r6: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && !rs_hit) |-> (rs_paddr == 32'd0 && !rs_rd && !rs_wr && !rs_ex && !rs_cache));

    // R8: access kind returned unchanged
    p_acc_echo_r8: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> (rs_acc == $past(lk_acc)));

endmodule

bind vtlb_lookup vtlb_lookup_chk #(
    .WAY_W (WAY_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lk_valid (lk_valid),
    .lk_vaddr (lk_vaddr),
    .lk_acc   (lk_acc),
    .rs_valid (rs_valid),
    .rs_hit   (rs_hit),
    .rs_paddr (rs_paddr),
    .rs_rd    (rs_rd),
    .rs_wr    (rs_wr),
    .rs_ex    (rs_ex),
    .rs_cache (rs_cache),
    .rs_acc   (rs_acc),
    .rs_way   (rs_way)
);

// File: tb/test_vtlb_lookup.sv
`timescale 1ns/1ps
module test_vtlb_lookup;

    localparam int NE = 16;
    localparam int NW = 4;
    localparam int PB = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_index;
    logic [31:0] wr_tag, wr_data;
    logic        lk_valid;
    logic [31:0] lk_vaddr;
    logic [1:0]  lk_acc;
    logic [7:0]  lk_pid;
    logic        rs_valid, rs_hit, rs_rd, rs_wr, rs_ex, rs_cache;
    logic [31:0] rs_paddr;
    logic [1:0]  rs_acc, rs_way;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vtlb_lookup #(.NUM_ENTRIES(NE), .NUM_WAYS(NW), .PID_BITS(PB)) i_vtlb_lookup (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_index(wr_index),
        .wr_tag(wr_tag), .wr_data(wr_data), .lk_valid(lk_valid),
        .lk_vaddr(lk_vaddr), .lk_acc(lk_acc), .lk_pid(lk_pid),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_paddr(rs_paddr),
        .rs_rd(rs_rd), .rs_wr(rs_wr), .rs_ex(rs_ex), .rs_cache(rs_cache),
        .rs_acc(rs_acc), .rs_way(rs_way)
    );

    typedef struct packed {
        logic [31:0] va;
        logic [7:0]  pid;
        logic [1:0]  acc;
        logic        hit;
        logic [31:0] pa;
        logic        c, r, w, x;
        logic [1:0]  way;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h0001_2345, 8'h05, 2'd0, 1'b1, 32'hABCD_E345, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0}, // R4 way0 beats global way1
        '{32'h0001_2FFF, 8'h07, 2'd1, 1'b1, 32'h1111_1FFF, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1}, // R3 global under other pid
        '{32'h0003_3010, 8'h00, 2'd2, 1'b1, 32'h2222_2010, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2}, // R3 global pid 0
        '{32'h0003_3010, 8'hFF, 2'd0, 1'b1, 32'h2222_2010, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2}, // R8 acc no effect
        '{32'h0004_0ABC, 8'h09, 2'd1, 1'b1, 32'h3333_3ABC, 1'b0, 1'b1, 1'b1, 1'b0, 2'd3}, // R5 pid match
        '{32'h0004_0ABC, 8'h08, 2'd1, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0}, // R3 wrong pid
        '{32'h0005_0000, 8'h00, 2'd0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0}, // R3 valid clear
        '{32'h0001_6000, 8'h05, 2'd0, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0}, // R3 vpn mismatch
        '{32'h0005_2000, 8'h00, 2'd2, 1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0}  // R9 wrong set
    };

    function automatic logic [31:0] mk_tag(input logic [19:0] vpn, input logic g,
                                           input logic v, input logic [7:0] pid);
        return {vpn, g, v, 2'b00, pid};
    endfunction

    function automatic logic [31:0] mk_data(input logic [19:0] pfn, input logic c,
                                            input logic r, input logic w, input logic x);
        return {8'h00, c, r, w, x, pfn};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [3:0] idx, input logic [31:0] t, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_index = idx; wr_tag = t; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] va, input logic [7:0] pid, input logic [1:0] acc);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_pid = pid; lk_acc = acc;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_index = '0; wr_tag = '0; wr_data = '0;
        lk_valid = 1'b0; lk_vaddr = '0; lk_acc = '0; lk_pid = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1", "rs_valid after reset", {31'd0, rs_valid}, 32'd0);
        chk("R1", "rs_hit after reset", {31'd0, rs_hit}, 32'd0);

        // R1: empty buffer misses, even for vpn 0 / pid 0
        look(32'h0000_0000, 8'h00, 2'd0);
        chk("R1", "empty miss", {31'd0, rs_hit}, 32'd0);
        chk("R7", "rs_valid one cycle after strobe", {31'd0, rs_valid}, 32'd1);

        // fill: slot = way*4 + (vpn & 3)
        put(4'd2,  mk_tag(20'h00012, 1'b0, 1'b1, 8'h05), mk_data(20'hABCDE, 1'b1, 1'b1, 1'b0, 1'b1));
        put(4'd6,  mk_tag(20'h00012, 1'b1, 1'b1, 8'h00), mk_data(20'h11111, 1'b0, 1'b1, 1'b1, 1'b0));
        put(4'd11, mk_tag(20'h00033, 1'b1, 1'b1, 8'h44), mk_data(20'h22222, 1'b0, 1'b0, 1'b0, 1'b1));
        put(4'd12, mk_tag(20'h00040, 1'b0, 1'b1, 8'h09), mk_data(20'h33333, 1'b0, 1'b1, 1'b1, 1'b0));
        put(4'd0,  mk_tag(20'h00050, 1'b1, 1'b0, 8'h00), mk_data(20'h55555, 1'b1, 1'b1, 1'b1, 1'b1));
        put(4'd1,  mk_tag(20'h00052, 1'b1, 1'b1, 8'h00), mk_data(20'h66666, 1'b1, 1'b1, 1'b1, 1'b1));

        for (int i = 0; i < NV; i++) begin
            look(VECS[i].va, VECS[i].pid, VECS[i].acc);
            chk("R3", $sformatf("vec%0d hit", i), {31'd0, rs_hit}, {31'd0, VECS[i].hit});
            chk("R5", $sformatf("vec%0d paddr", i), rs_paddr, VECS[i].pa);
            chk("R6", $sformatf("vec%0d perms", i), {28'd0, rs_cache, rs_rd, rs_wr, rs_ex},
                {28'd0, VECS[i].c, VECS[i].r, VECS[i].w, VECS[i].x});
            chk("R8", $sformatf("vec%0d acc", i), {30'd0, rs_acc}, {30'd0, VECS[i].acc});
            if (VECS[i].hit)
                chk("R4", $sformatf("vec%0d way", i), {30'd0, rs_way}, {30'd0, VECS[i].way});
        end

        // R7: hold while idle
        look(32'h0004_0123, 8'h09, 2'd2);
        @(negedge clk);
        chk("R7", "rs_valid low when idle", {31'd0, rs_valid}, 32'd0);
        chk("R7", "hit held", {31'd0, rs_hit}, 32'd1);
        chk("R7", "paddr held", rs_paddr, 32'h3333_3123);

        // R2: overwrite an entry
        put(4'd11, mk_tag(20'h00033, 1'b1, 1'b1, 8'h00), mk_data(20'h44444, 1'b0, 1'b1, 1'b0, 1'b0));
        look(32'h0003_3010, 8'h12, 2'd0);
        chk("R2", "overwritten paddr", rs_paddr, 32'h4444_4010);
        chk("R2", "overwritten perms", {29'd0, rs_rd, rs_wr, rs_ex}, 32'd4);

        // R1: reset clears stored entries
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1", "rs_hit cleared by reset", {31'd0, rs_hit}, 32'd0);
        look(32'h0001_2345, 8'h05, 2'd0);
        chk("R1", "miss after reset", {31'd0, rs_hit}, 32'd0);
        chk("R1", "paddr zero after reset", rs_paddr, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule